// File: doc/BRIEF.md
# Serial Bus Control and Interrupt Register File

This block is the register file that software uses to drive a two-wire serial command engine. A 32-bit register bus with separate read and write strobes reaches the control, clock, interrupt, status, address, data, command, device-address, line-override and device-mode registers. The block turns register writes into single-cycle go, abort and initialisation pulses towards the engine. It tracks whether a transfer or an initialisation sequence is in flight, and it records completion and error results in a write-one-to-clear status word. It drives one interrupt line from that word.

The wire timing belongs to the engine. The engine reports back through a done strobe that carries error qualifiers and optional read data, and through a separate init-done strobe. The bus read path is combinational: `bus_rdata` shows the addressed register while `bus_rd` is high and is zero otherwise. A write takes effect at the clock edge on which `bus_wr` is sampled high.

Top module: `sbus_regfile`

## Requirements
- R1: After reset, control, status, interrupt-enable, clock, address, data, command, device-address and line registers read 0, the device-mode register (offset 0x28) reads 0x007C3E00, and `irq` is low.
- R2: Writing control (0x00) with bit 7 set while idle gives exactly one `eng_go` pulse. Control bit 7 then reads 1 until the engine's `eng_done` strobe.
- R3: Writing control bit 7 while a transfer is active gives no `eng_go` pulse and sets status bit 2 (load busy).
- R4: A done strobe without error sets status bit 0. A done strobe with `eng_err` sets status bit 1, loads `eng_err_data` into status bits 11:8, and sets status bit 16 when `eng_err_ack` is high. Status lives at offset 0x0C.
- R5: Writing status clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: `irq` is high exactly when control bit 1 is set and some status bit among 2:0 is set together with the same bit of the interrupt-enable register (0x08).
- R7: Writing control bit 6 gives one `eng_abort` pulse and ends the active transfer. A later done strobe is then ignored, and bits 6 and 7 read 0.
- R8: Writing control bit 0 starts a soft reset. Bit 0 reads 1 for exactly 4 cycles, the active transfer ends, all status bits clear, and `eng_abort` is held high throughout.
- R9: Writing device-mode bit 31 while no sequence is running gives one `eng_init_go` pulse and stores bits 23:0. Bit 31 reads 1 until `eng_init_done`. Writes made while the sequence runs change nothing.
- R10: Line register (0x24) bits 0..3 drive `sda_ovr_en`, `sda_ovr_val`, `scl_ovr_en` and `scl_ovr_val`. Bits 4 and 5 read the live `sda_in` and `scl_in`.
- R11: The clock register (0x04, 11 bits), address (0x10, 8 bits), data (0x1C, 32 bits), command (0x2C, 8 bits) and device address (0x30, 24 bits) read back what was written, masked to their widths, and appear on the `cfg_*` outputs.
- R12: A done strobe with `eng_rdata_vld` loads `eng_rdata` into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| eng_go | output | 1 | Start-transfer pulse |
| eng_abort | output | 1 | Abort pulse, held during soft reset |
| eng_init_go | output | 1 | Start-initialisation pulse |
| eng_done | input | 1 | Transfer finished strobe |
| eng_err | input | 1 | Transfer failed, with eng_done |
| eng_err_ack | input | 1 | Failure was an acknowledge error |
| eng_err_data | input | 4 | Failing data byte indicator |
| eng_rdata_vld | input | 1 | eng_rdata carries read data |
| eng_rdata | input | 32 | Read data from the engine |
| eng_init_done | input | 1 | Initialisation sequence sent |
| cfg_clk | output | 11 | Clock divider and output delay setting |
| cfg_reg_addr | output | 8 | Target register address |
| cfg_wdata | output | 32 | Data register |
| cfg_cmd | output | 8 | Command code |
| cfg_dev | output | 24 | Runtime and hardware device address |
| cfg_init | output | 24 | Initialisation mode data, register and address |
| sda_ovr_en | output | 1 | Force SDA |
| sda_ovr_val | output | 1 | Forced SDA level |
| scl_ovr_en | output | 1 | Force SCL |
| scl_ovr_val | output | 1 | Forced SCL level |
| sda_in | input | 1 | Live SDA state |
| scl_in | input | 1 | Live SCL state |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle. A go pulse lasts one cycle and only comes with a transfer marked active. A load-busy flag only rises while a transfer is active. An abort never leaves a transfer active. Status stays empty after a soft-reset cycle. A running initialisation holds until its done strobe. The interrupt stays low with the global enable off. The line outputs change only on a write to their register. Other behaviour needs the directed scenarios: the exact four-cycle soft-reset window, the error field contents, selective write-one-to-clear, readback masking, the effect of read data on the data register, and done strobes that are ignored after an abort.

// File: rtl/sbus_reg_pkg.sv
// Package: register offsets, bit positions and the status record shared by
// the register file, its sub-blocks and its checker.
package sbus_reg_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_CLK   = 8'h04;
    localparam logic [7:0] OFS_IEN   = 8'h08;
    localparam logic [7:0] OFS_STS   = 8'h0C;
    localparam logic [7:0] OFS_ADR   = 8'h10;
    localparam logic [7:0] OFS_DAT   = 8'h1C;
    localparam logic [7:0] OFS_LINE  = 8'h24;
    localparam logic [7:0] OFS_DMODE = 8'h28;
    localparam logic [7:0] OFS_CMD   = 8'h2C;
    localparam logic [7:0] OFS_DEV   = 8'h30;

    localparam int CTL_GO   = 7;
    localparam int CTL_ABT  = 6;
    localparam int CTL_GIE  = 1;
    localparam int CTL_SRST = 0;
    localparam int DM_GO    = 31;

    // Latched completion status; packed so a W1C mask lines up field by field.
    typedef struct packed {
        logic       ack;
        logic [3:0] edata;
        logic       lbsy;
        logic       err;
        logic       over;
    } sts_t;
endpackage

// File: rtl/sbus_xfer_ctl.sv
// Transfer sequencer: turns decoded control writes into engine pulses and
// tracks transfer, initialisation and soft-reset activity.
// Assumes requests are single-cycle decoded write strobes from the register file.
module sbus_xfer_ctl #(
    parameter int SRST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    input  logic abort_req,
    input  logic srst_req,
    input  logic init_req,
    input  logic eng_done,
    input  logic eng_init_done,
    output logic busy,
    output logic init_busy,
    output logic srst_active,
    output logic eng_go,
    output logic eng_abort,
    output logic eng_init_go,
    output logic lbsy_evt,
    output logic done_evt
);
    localparam int CW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SRST_CYCLES - 1);

    logic [CW-1:0] srst_cnt;
    logic          abort_pls;
    logic          quiet;

    // Requests are honoured only outside a soft reset and without an abort.
    assign quiet     = !srst_active && !srst_req;
    assign lbsy_evt  = quiet && !abort_req && go_req && busy;
    assign done_evt  = quiet && !abort_req && busy && eng_done;
    assign eng_abort = abort_pls || srst_active;

    // Sequencer state: soft-reset window, transfer and init activity, pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            init_busy   <= 1'b0;
            srst_active <= 1'b0;
            srst_cnt    <= '0;
            eng_go      <= 1'b0;
            abort_pls   <= 1'b0;
            eng_init_go <= 1'b0;
        end else begin
            eng_go      <= 1'b0;
            abort_pls   <= 1'b0;
            eng_init_go <= 1'b0;
            if (srst_active) begin
                srst_cnt  <= srst_cnt + 1'b1;
                busy      <= 1'b0;
                init_busy <= 1'b0;
                if (srst_cnt == CNT_LAST) begin
                    srst_active <= 1'b0;
                end
            end else if (srst_req) begin
                srst_active <= 1'b1;
                srst_cnt    <= '0;
                busy        <= 1'b0;
                init_busy   <= 1'b0;
            end else begin
                if (abort_req) begin
                    busy      <= 1'b0;
                    abort_pls <= 1'b1;
                end else if (go_req && !busy) begin
                    busy   <= 1'b1;
                    eng_go <= 1'b1;
                end else if (busy && eng_done) begin
                    busy <= 1'b0;
                end
                if (init_req && !init_busy) begin
                    init_busy   <= 1'b1;
                    eng_init_go <= 1'b1;
                end else if (init_busy && eng_init_done) begin
                    init_busy <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sbus_irq_status.sv
// Status word with write-one-to-clear access, plus the interrupt combiner.
// Assumes event inputs are already qualified; a set and a clear in the same
// cycle leave the bit set.
module sbus_irq_status
    import sbus_reg_pkg::*;
#(
    parameter int IRQ_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic               w1c_en,
    input  sts_t               w1c_mask,
    input  logic               done_evt,
    input  logic               err,
    input  logic               err_ack,
    input  logic [3:0]         err_data,
    input  logic               lbsy_evt,
    input  logic [IRQ_SRC-1:0] ien,
    input  logic               gie,
    output sts_t               sts,
    output logic               irq
);
    sts_t set_v;
    sts_t clr_v;
    logic [IRQ_SRC-1:0] src;

    // Build the per-field set and clear vectors.
    always_comb begin
        set_v       = '0;
        set_v.over  = done_evt && !err;
        set_v.err   = done_evt && err;
        set_v.edata = (done_evt && err) ? err_data : 4'h0;
        set_v.ack   = done_evt && err && err_ack;
        set_v.lbsy  = lbsy_evt;
        clr_v       = w1c_en ? w1c_mask : '0;
    end

    // Status register update: a hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~clr_v) | set_v;
        end
    end

    assign src = {sts.lbsy, sts.err, sts.over};
    assign irq = gie && |(src & ien);
endmodule

// File: rtl/sbus_regfile.sv
// Top register file in front of the serial command engine. It decodes bus
// accesses, holds the configuration registers, and forwards control to the
// sequencer and the status block. Assumes single-cycle write strobes; reads
// are combinational and gated by bus_rd.
module sbus_regfile
    import sbus_reg_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          CLKCFG_W    = 11,
    parameter int          DEV_W       = 24,
    parameter int          SRST_CYCLES = 4,
    parameter logic [23:0] DMODE_RST   = 24'h7C3E00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                eng_go,
    output logic                eng_abort,
    output logic                eng_init_go,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic                eng_err_ack,
    input  logic [3:0]          eng_err_data,
    input  logic                eng_rdata_vld,
    input  logic [DATA_W-1:0]   eng_rdata,
    input  logic                eng_init_done,
    output logic [CLKCFG_W-1:0] cfg_clk,
    output logic [7:0]          cfg_reg_addr,
    output logic [DATA_W-1:0]   cfg_wdata,
    output logic [7:0]          cfg_cmd,
    output logic [DEV_W-1:0]    cfg_dev,
    output logic [23:0]         cfg_init,
    output logic                sda_ovr_en,
    output logic                sda_ovr_val,
    output logic                scl_ovr_en,
    output logic                scl_ovr_val,
    input  logic                sda_in,
    input  logic                scl_in,
    output logic                irq
);
    localparam int IRQ_SRC = 3;

    logic               wr_ctrl, wr_sts, wr_dmode;
    logic               gie;
    logic [IRQ_SRC-1:0] ien;
    logic [3:0]         line_q;
    logic               busy, init_busy, srst_active, lbsy_evt, done_evt;
    sts_t               sts, w1c_mask;

    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_sts   = bus_wr && (bus_addr == OFS_STS);
    assign wr_dmode = bus_wr && (bus_addr == OFS_DMODE);
    assign w1c_mask = '{ack: bus_wdata[16], edata: bus_wdata[11:8],
                        lbsy: bus_wdata[2], err: bus_wdata[1], over: bus_wdata[0]};

    sbus_xfer_ctl #(.SRST_CYCLES(SRST_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_req       (wr_ctrl && bus_wdata[CTL_GO]),
        .abort_req    (wr_ctrl && bus_wdata[CTL_ABT]),
        .srst_req     (wr_ctrl && bus_wdata[CTL_SRST]),
        .init_req     (wr_dmode && bus_wdata[DM_GO]),
        .eng_done     (eng_done),
        .eng_init_done(eng_init_done),
        .busy         (busy),
        .init_busy    (init_busy),
        .srst_active  (srst_active),
        .eng_go       (eng_go),
        .eng_abort    (eng_abort),
        .eng_init_go  (eng_init_go),
        .lbsy_evt     (lbsy_evt),
        .done_evt     (done_evt)
    );

    sbus_irq_status #(.IRQ_SRC(IRQ_SRC)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (srst_active),
        .w1c_en  (wr_sts),
        .w1c_mask(w1c_mask),
        .done_evt(done_evt),
        .err     (eng_err),
        .err_ack (eng_err_ack),
        .err_data(eng_err_data),
        .lbsy_evt(lbsy_evt),
        .ien     (ien),
        .gie     (gie),
        .sts     (sts),
        .irq     (irq)
    );

    // Configuration registers written from the bus; data also loads from the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie          <= 1'b0;
            ien          <= '0;
            cfg_clk      <= '0;
            cfg_reg_addr <= '0;
            cfg_wdata    <= '0;
            cfg_cmd      <= '0;
            cfg_dev      <= '0;
            cfg_init     <= DMODE_RST;
            line_q       <= '0;
        end else begin
            if (wr_ctrl) gie <= bus_wdata[CTL_GIE];
            if (bus_wr && bus_addr == OFS_IEN) ien <= bus_wdata[IRQ_SRC-1:0];
            if (bus_wr && bus_addr == OFS_CLK) cfg_clk <= bus_wdata[CLKCFG_W-1:0];
            if (bus_wr && bus_addr == OFS_ADR) cfg_reg_addr <= bus_wdata[7:0];
            if (bus_wr && bus_addr == OFS_CMD) cfg_cmd <= bus_wdata[7:0];
            if (bus_wr && bus_addr == OFS_DEV) cfg_dev <= bus_wdata[DEV_W-1:0];
            if (bus_wr && bus_addr == OFS_LINE) line_q <= bus_wdata[3:0];
            if (wr_dmode && !init_busy) cfg_init <= bus_wdata[23:0];
            if (done_evt && eng_rdata_vld) begin
                cfg_wdata <= eng_rdata;
            end else if (bus_wr && bus_addr == OFS_DAT) begin
                cfg_wdata <= bus_wdata;
            end
        end
    end

    assign sda_ovr_en  = line_q[0];
    assign sda_ovr_val = line_q[1];
    assign scl_ovr_en  = line_q[2];
    assign scl_ovr_val = line_q[3];

    // Combinational read multiplexer, zero outside a read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL:  bus_rdata = DATA_W'({busy, 5'b0, gie, srst_active});
                OFS_CLK:   bus_rdata = DATA_W'(cfg_clk);
                OFS_IEN:   bus_rdata = DATA_W'(ien);
                OFS_STS:   bus_rdata = DATA_W'({sts.ack, 4'b0, sts.edata, 5'b0,
                                                sts.lbsy, sts.err, sts.over});
                OFS_ADR:   bus_rdata = DATA_W'(cfg_reg_addr);
                OFS_DAT:   bus_rdata = cfg_wdata;
                OFS_LINE:  bus_rdata = DATA_W'({scl_in, sda_in, line_q});
                OFS_DMODE: bus_rdata = DATA_W'({init_busy, 7'b0, cfg_init});
                OFS_CMD:   bus_rdata = DATA_W'(cfg_cmd);
                OFS_DEV:   bus_rdata = DATA_W'(cfg_dev);
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sbus_regfile_chk.sv
// Checker for sbus_regfile: cycle-by-cycle protocol rules on the sequencer,
// status and line outputs. Attached through bind; observes only.
module sbus_regfile_chk
    import sbus_reg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       eng_go,
    input logic       eng_abort,
    input logic       eng_init_done,
    input logic       busy,
    input logic       init_busy,
    input logic       srst_active,
    input logic       gie,
    input logic       irq,
    input sts_t       sts,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic [3:0] line_q
);
    // R2: a go pulse lasts one cycle and comes with an active transfer.
    p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> !eng_go);
    p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> busy);
    // R3: load busy only rises after a start during an active transfer.
    p_lbsy_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts.lbsy) |-> $past(busy));
    // R6: interrupt stays low with the global enable off.
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);
    // R7: an abort never leaves a transfer active.
    p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !busy);
    // R8: status is empty after every soft-reset cycle.
    p_srst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_active |=> (sts == '0));
    // R9: a running initialisation holds until its done strobe.
    p_init_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && !eng_init_done && !srst_active) |=> init_busy);
    // R10: line outputs only change on a write to the line register.
    p_line_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_LINE) |=> $stable(line_q));
endmodule

bind sbus_regfile sbus_regfile_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .eng_go       (eng_go),
    .eng_abort    (eng_abort),
    .eng_init_done(eng_init_done),
    .busy         (busy),
    .init_busy    (init_busy),
    .srst_active  (srst_active),
    .gie          (gie),
    .irq          (irq),
    .sts          (sts),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .line_q       (line_q)
);

// File: tb/sbus_regfile_tb_top.sv
// Directed bench for sbus_regfile: one task per scenario, each checking itself.
module sbus_regfile_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        eng_go, eng_abort, eng_init_go;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_err_ack = 1'b0;
    logic [3:0]  eng_err_data = '0;
    logic        eng_rdata_vld = 1'b0;
    logic [31:0] eng_rdata = '0;
    logic        eng_init_done = 1'b0;
    logic [10:0] cfg_clk;
    logic [7:0]  cfg_reg_addr, cfg_cmd;
    logic [31:0] cfg_wdata;
    logic [23:0] cfg_dev, cfg_init;
    logic        sda_ovr_en, sda_ovr_val, scl_ovr_en, scl_ovr_val;
    logic        sda_in = 1'b0, scl_in = 1'b0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    int go_cnt = 0, abt_cnt = 0, init_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbus_regfile dut_i (.*);

    // Pulse monitors counting engine strobes at clock edges.
    always @(posedge clk) begin
        if (eng_go) go_cnt++;
        if (eng_abort) abt_cnt++;
        if (eng_init_go) init_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic done(input logic e, input logic ack, input logic [3:0] ed,
                        input logic vld, input logic [31:0] rdv);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e; eng_err_ack = ack; eng_err_data = ed;
        eng_rdata_vld = vld; eng_rdata = rdv;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0; eng_err_ack = 1'b0; eng_err_data = '0;
        eng_rdata_vld = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h0C, v); check("R1 sts", v, 0);
        rd(8'h04, v); check("R1 clk", v, 0);
        rd(8'h24, v); check("R1 line", v, 0);
        rd(8'h28, v); check("R1 dmode", v, 32'h007C3E00);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_start_done();
        logic [31:0] v;
        int g0 = go_cnt;
        wr(8'h00, 32'h80);
        rd(8'h00, v); check("R2 busy bit", v, 32'h80);
        @(negedge clk);
        check("R2 one go", go_cnt - g0, 1);
        done(0, 0, 0, 0, 0);
        rd(8'h00, v); check("R2 idle after done", v, 0);
        rd(8'h0C, v); check("R4 over", v, 32'h1);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_start_busy();
        logic [31:0] v;
        int g0 = go_cnt;
        wr(8'h00, 32'h80);
        wr(8'h00, 32'h80);
        @(negedge clk);
        check("R3 no second go", go_cnt - g0, 1);
        rd(8'h0C, v); check("R3 load busy", v, 32'h4);
        done(0, 0, 0, 0, 0);
        rd(8'h0C, v); check("R3 lbsy plus over", v, 32'h5);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        wr(8'h00, 32'h80);
        done(1, 1, 4'hA, 0, 0);
        rd(8'h0C, v); check("R4 ack error", v, 32'h0001_0A02);
        // R5 selective clears
        wr(8'h0C, 32'h2);
        rd(8'h0C, v); check("R5 clear err only", v, 32'h0001_0A00);
        wr(8'h0C, 32'h800);
        rd(8'h0C, v); check("R5 clear edata bit", v, 32'h0001_0200);
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); check("R5 zero write keeps", v, 32'h0001_0200);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h00, 32'h80);
        done(1, 0, 4'h3, 0, 0);
        rd(8'h0C, v); check("R4 data error", v, 32'h0000_0302);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h82);
        done(0, 0, 0, 0, 0);
        check("R6 irq on", irq, 1);
        wr(8'h08, 32'h2);
        check("R6 irq masked", irq, 0);
        wr(8'h08, 32'h1);
        check("R6 irq again", irq, 1);
        wr(8'h00, 32'h0);
        check("R6 gie off", irq, 0);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int a0;
        wr(8'h00, 32'h80);
        a0 = abt_cnt;
        wr(8'h00, 32'h40);
        @(negedge clk);
        check("R7 one abort", abt_cnt - a0, 1);
        rd(8'h00, v); check("R7 ctrl idle", v, 0);
        done(0, 0, 0, 0, 0);
        rd(8'h0C, v); check("R7 late done ignored", v, 0);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        int a0;
        wr(8'h00, 32'h80);
        done(0, 0, 0, 0, 0);
        wr(8'h00, 32'h80);
        a0 = abt_cnt;
        wr(8'h00, 32'h01);
        rd(8'h00, v); check("R8 srst first cycle", v, 32'h01);
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R8 srst fourth cycle", v, 32'h01);
        @(negedge clk);
        rd(8'h00, v); check("R8 srst self clear", v, 0);
        rd(8'h0C, v); check("R8 status cleared", v, 0);
        check("R8 abort held", abt_cnt - a0, 4);
    endtask

    task automatic t_init();
        logic [31:0] v;
        int i0 = init_cnt;
        wr(8'h28, 32'h8012_3456);
        rd(8'h28, v); check("R9 init running", v, 32'h8012_3456);
        check("R9 cfg_init", cfg_init, 32'h0012_3456);
        wr(8'h28, 32'h80FF_FFFF);
        @(negedge clk);
        check("R9 one init go", init_cnt - i0, 1);
        rd(8'h28, v); check("R9 busy write ignored", v, 32'h8012_3456);
        @(negedge clk); eng_init_done = 1'b1;
        @(negedge clk); eng_init_done = 1'b0;
        rd(8'h28, v); check("R9 init finished", v, 32'h0012_3456);
    endtask

    task automatic t_line();
        logic [31:0] v;
        wr(8'h24, 32'hF);
        check("R10 outs all", {sda_ovr_en, sda_ovr_val, scl_ovr_en, scl_ovr_val}, 4'hF);
        sda_in = 1'b1; scl_in = 1'b0;
        rd(8'h24, v); check("R10 sda live", v, 32'h1F);
        sda_in = 1'b0; scl_in = 1'b1;
        rd(8'h24, v); check("R10 scl live", v, 32'h2F);
        wr(8'h24, 32'h5);
        check("R10 enables only", {sda_ovr_en, sda_ovr_val, scl_ovr_en, scl_ovr_val}, 4'hA);
    endtask

    task automatic t_config();
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R11 clk mask", v, 32'h7FF);
        wr(8'h10, 32'h1234);      rd(8'h10, v); check("R11 addr mask", v, 32'h34);
        wr(8'h2C, 32'h18B);       rd(8'h2C, v); check("R11 cmd mask", v, 32'h8B);
        wr(8'h30, 32'hFF2D_03A3); rd(8'h30, v); check("R11 dev mask", v, 32'h2D_03A3);
        check("R11 cfg_dev", cfg_dev, 32'h2D_03A3);
        wr(8'h1C, 32'hDEAD_BEEF); rd(8'h1C, v); check("R11 data", v, 32'hDEAD_BEEF);
        check("R11 cfg_wdata", cfg_wdata, 32'hDEAD_BEEF);
    endtask

    task automatic t_rdata();
        logic [31:0] v;
        wr(8'h00, 32'h80);
        done(0, 0, 0, 1, 32'hCAFE_0042);
        rd(8'h1C, v); check("R12 read data load", v, 32'hCAFE_0042);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_done();
        t_start_busy();
        t_errors();
        t_irq();
        t_abort();
        t_srst();
        t_init();
        t_line();
        t_config();
        t_rdata();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule